// File: doc/BRIEF.md
# Bounded-Wait Buffer Access Client

This block sits between a client process and a shared slot buffer that answers over a four-phase start/done handshake. Each time the client asks for an access, the wrapper raises start. It then waits for done, but only for a fixed number of clock cycles. When the wait ends, it reports in a single-cycle status pulse whether the buffer finished or the wait ran out. The client can therefore go on with its own cycle after a known worst-case delay, whatever the other side of the buffer is doing.

A parameter selects one of two builds. A writer presents the client's item to the buffer for the length of the access. When a writer times out, that item is dropped and never issued again. A reader captures the buffer's data on completion. When a reader times out, it keeps the item it obtained on the last completed access. After a timeout, the wrapper still finishes the handshake on its own: it holds start until done arrives, then drops start and waits for done to fall. The wait bound is the parameter `MAX_WAIT`. Its value is worked out outside the block, as the sum of the buffer's internal step times plus one lost arbitration on the local side.

Top module: `bw_client`

## Requirements
- R1: During and right after reset, buf_start_o, stat_end_o, stat_tmo_o and fresh_o are 0, and cl_rdata_o is 0.
- R2: A req_i sampled high while idle raises buf_start_o at that edge. In writer mode, buf_wdata_o takes cl_wdata_i from that same edge and stays stable while buf_start_o is high.
- R3: If buf_done_i is sampled high at any of the first MAX_WAIT rising edges after buf_start_o rose, that edge drops buf_start_o and raises stat_end_o with stat_tmo_o=0 and fresh_o=1.
- R4: If buf_done_i is not sampled high in those MAX_WAIT edges, the MAX_WAIT-th edge raises stat_end_o with stat_tmo_o=1 and fresh_o=0, and buf_start_o stays high.
- R5: After a timeout, buf_start_o stays high until buf_done_i is sampled high and then falls. After any access, no new start is issued until buf_done_i has been sampled low.
- R6: stat_end_o is high for exactly one cycle per access. It never pulses for the late done that follows a timeout. stat_tmo_o and fresh_o hold their value until the next pulse.
- R7: In reader mode, cl_rdata_o takes buf_rdata_i at the completing edge. It stays unchanged on a timeout, and data that arrives with a late done is not taken.
- R8: In writer mode, a timed-out item is not issued again. No start follows unless there is a new req_i, and the next access carries the new cl_wdata_i.
- R9: A req_i that arrives while an access or its handshake return is in progress is ignored and starts no access.
- R10: A done sampled on exactly the MAX_WAIT-th edge counts as completion, not timeout.
- R11: Every access gets a full MAX_WAIT window, including one that directly follows a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Client asks for one access |
| cl_wdata_i | input | DATA_W | Client item to write (writer mode) |
| buf_start_o | output | 1 | Handshake start toward the buffer |
| buf_wdata_o | output | DATA_W | Item presented to the buffer (writer mode, else 0) |
| buf_done_i | input | 1 | Handshake done from the buffer |
| buf_rdata_i | input | DATA_W | Buffer data, valid with done (reader mode) |
| cl_rdata_o | output | DATA_W | Item handed to the client (reader mode, else 0) |
| stat_end_o | output | 1 | One-cycle pulse when an access ends |
| stat_tmo_o | output | 1 | Outcome of the last access: 1 timeout, 0 completed |
| fresh_o | output | 1 | Last access completed, so its data is new or committed |

## Verification
The bench sweeps the done delay across the whole window. It uses the first edge, the last edge inside the bound and the first edge past it, and the boundary runs separate completion from timeout by a single cycle. Late dones that arrive several cycles after expiry, with the done held high for extra cycles, test whether start is held and released correctly and whether late data leaks to the client. Requests raised during a wait or during the return-to-zero phase test whether stray requests are ignored. A timeout followed straight away by a boundary-delay access checks that the window restarts. A seeded random mix of delays, hold lengths and stray requests then runs writer and reader builds side by side.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LATE = 2'd2,
    ST_RTZ  = 2'd3
  } bw_state_e;

  typedef enum logic {
    MODE_WRITE = 1'b0,
    MODE_READ  = 1'b1
  } bw_mode_e;
endpackage

// File: rtl/bw_timer.sv
module bw_timer #(
  parameter int unsigned MAX_WAIT = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_WAIT - 1);

  logic [CNT_W-1:0] cnt_q;

  // cnt_q = number of waiting edges already passed since start+
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (run_i && (cnt_q != LAST))  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_clr_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/bw_hs_fsm.sv
module bw_hs_fsm
  import bw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic done_i,
  input  logic expire_i,
  output logic start_o,
  output logic run_o,
  output logic load_o,
  output logic capture_o,
  output logic end_o,
  output logic tmo_o,
  output logic fresh_o
);
  bw_state_e state_q;
  logic start_q, end_q, tmo_q, fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      tmo_q   <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      end_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_WAIT;
          start_q <= 1'b1;
        end
        ST_WAIT: if (done_i) begin
          state_q <= ST_RTZ;
          start_q <= 1'b0;
          end_q   <= 1'b1;
          tmo_q   <= 1'b0;
          fresh_q <= 1'b1;
        end else if (expire_i) begin
          // report now, finish the handshake in the background
          state_q <= ST_LATE;
          end_q   <= 1'b1;
          tmo_q   <= 1'b1;
          fresh_q <= 1'b0;
        end
        ST_LATE: if (done_i) begin
          state_q <= ST_RTZ;
          start_q <= 1'b0;
        end
        ST_RTZ: if (!done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o    = (state_q == ST_IDLE) && req_i;
  assign run_o     = (state_q == ST_WAIT);
  assign capture_o = run_o && done_i;
  assign start_o   = start_q;
  assign end_o     = end_q;
  assign tmo_o     = tmo_q;
  assign fresh_o   = fresh_q;

  p_start_until_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && !done_i) |=> start_q);
  p_rtz_no_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RTZ) |=> !start_q);
  p_end_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |=> !end_q);
  p_tmo_keeps_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_q && tmo_q) |-> (start_q && !fresh_q));
  p_ok_drops_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_q && !tmo_q) |-> (!start_q && fresh_q));
  p_busy_req_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !start_q) |=> !start_q);
endmodule

// File: rtl/bw_datapath.sv
module bw_datapath
  import bw_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter bw_mode_e    MODE   = MODE_READ
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] cl_wdata_i,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic [DATA_W-1:0] buf_wdata_o,
  output logic [DATA_W-1:0] cl_rdata_o
);
  if (MODE == MODE_WRITE) begin : g_wr
    logic [DATA_W-1:0] wdata_q;
    logic unused_rd;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     wdata_q <= '0;
      else if (load_i) wdata_q <= cl_wdata_i;
    end
    assign unused_rd   = ^{buf_rdata_i, capture_i};
    assign buf_wdata_o = wdata_q;
    assign cl_rdata_o  = '0;
  end else begin : g_rd
    logic [DATA_W-1:0] rdata_q;
    logic unused_wr;
    // only an in-window done updates; timeouts keep the previous item
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rdata_q <= '0;
      else if (capture_i) rdata_q <= buf_rdata_i;
    end
    assign unused_wr   = ^{cl_wdata_i, load_i};
    assign buf_wdata_o = '0;
    assign cl_rdata_o  = rdata_q;
  end
endmodule

// File: rtl/bw_client.sv
module bw_client
  import bw_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAX_WAIT = 12,
  parameter bw_mode_e    MODE     = MODE_READ
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] cl_wdata_i,
  output logic              buf_start_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  input  logic              buf_done_i,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic [DATA_W-1:0] cl_rdata_o,
  output logic              stat_end_o,
  output logic              stat_tmo_o,
  output logic              fresh_o
);
  logic run, load, capture, expire;

  bw_timer #(.MAX_WAIT(MAX_WAIT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load),
    .run_i    (run),
    .expire_o (expire)
  );

  bw_hs_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .done_i    (buf_done_i),
    .expire_i  (expire),
    .start_o   (buf_start_o),
    .run_o     (run),
    .load_o    (load),
    .capture_o (capture),
    .end_o     (stat_end_o),
    .tmo_o     (stat_tmo_o),
    .fresh_o   (fresh_o)
  );

  bw_datapath #(.DATA_W(DATA_W), .MODE(MODE)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .capture_i   (capture),
    .cl_wdata_i  (cl_wdata_i),
    .buf_rdata_i (buf_rdata_i),
    .buf_wdata_o (buf_wdata_o),
    .cl_rdata_o  (cl_rdata_o)
  );

  p_tmo_keeps_rdata_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_end_o && stat_tmo_o) |-> $stable(cl_rdata_o));
  p_wdata_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_start_o && $past(buf_start_o)) |-> $stable(buf_wdata_o));
  p_no_pulse_late_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(buf_start_o) && stat_tmo_o |-> !stat_end_o);
endmodule

// File: tb/bw_client_tb_top.sv
`timescale 1ns/1ps
module bw_client_tb_top;
  import bw_pkg::*;

  localparam int W  = 6;
  localparam int DW = 8;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, done = 1'b0;
  logic [DW-1:0] wdata = '0, rdata = '0;

  logic r_start, r_end, r_tmo, r_fresh;
  logic w_start, w_end, w_tmo, w_fresh;
  logic [DW-1:0] r_rdata, r_wbuf, w_rdata, w_wbuf;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] exp_rdata = '0;
  logic last_to = 1'b0;

  always #4 clk = ~clk;

  bw_client #(.DATA_W(DW), .MAX_WAIT(W), .MODE(MODE_READ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cl_wdata_i(wdata),
    .buf_start_o(r_start), .buf_wdata_o(r_wbuf), .buf_done_i(done),
    .buf_rdata_i(rdata), .cl_rdata_o(r_rdata), .stat_end_o(r_end),
    .stat_tmo_o(r_tmo), .fresh_o(r_fresh));

  bw_client #(.DATA_W(DW), .MAX_WAIT(W), .MODE(MODE_WRITE)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cl_wdata_i(wdata),
    .buf_start_o(w_start), .buf_wdata_o(w_wbuf), .buf_done_i(done),
    .buf_rdata_i(rdata), .cl_rdata_o(w_rdata), .stat_end_o(w_end),
    .stat_tmo_o(w_tmo), .fresh_o(w_fresh));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic times_out(input int d);
    return d > W;
  endfunction

  task automatic ctl(input logic st, input logic en, input string tag);
    chk(r_start, st, {tag, " start rd"});
    chk(w_start, st, {tag, " start wr"});
    chk(r_end, en, {tag, " end rd"});
    chk(w_end, en, {tag, " end wr"});
  endtask

  // d: edge index after start+ at which done is first sampled high
  task automatic access(input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                        input int d, input int hold, input logic busy);
    logic to;
    to = times_out(d);
    @(negedge clk); req = 1'b1; wdata = wd; done = 1'b0;
    @(negedge clk); req = 1'b0; wdata = ~wd;
    ctl(1'b1, 1'b0, "R2 start raised");
    chk(w_wbuf, wd, "R2 item presented");
    for (int i = 1; i <= d; i++) begin
      req   = busy && (i == 1);
      done  = (i == d);
      rdata = (i == d) ? rd : ~rd;
      @(negedge clk);
      req = 1'b0;
      chk(w_wbuf, wd, "R2 item stable");
      if (!to) begin
        if (i < d) ctl(1'b1, 1'b0, "R3 waiting");
        else begin
          ctl(1'b0, 1'b1, "R3 completion");
          chk(r_tmo, 0, "R3 tmo rd"); chk(w_tmo, 0, "R3 tmo wr");
          chk(r_fresh, 1, "R3 fresh rd"); chk(w_fresh, 1, "R3 fresh wr");
          exp_rdata = rd;
          chk(r_rdata, exp_rdata, "R7 captured");
          if (d == W) chk(r_tmo, 0, "R10 last-edge done wins");
          if (last_to) chk(r_end, 1, "R11 window restarted");
        end
      end else begin
        if (i == W) begin
          ctl(1'b1, 1'b1, "R4 expiry");
          chk(r_tmo, 1, "R4 tmo rd"); chk(w_tmo, 1, "R4 tmo wr");
          chk(r_fresh, 0, "R4 fresh rd"); chk(w_fresh, 0, "R4 fresh wr");
          chk(r_rdata, exp_rdata, "R7 kept on timeout");
        end else if (i == d) begin
          ctl(1'b0, 1'b0, "R5 late done releases, R6 no pulse");
          chk(r_rdata, exp_rdata, "R7 late data not taken");
        end else begin
          ctl(1'b1, 1'b0, "R5 start held");
        end
      end
    end
    for (int h = 0; h < hold; h++) begin
      req = busy;
      @(negedge clk);
      req = 1'b0;
      ctl(1'b0, 1'b0, "R5 no start while done high");
    end
    done = 1'b0;
    @(negedge clk);
    ctl(1'b0, 1'b0, "R5 return to zero");
    chk(r_tmo, to, "R6 outcome held");
    chk(r_fresh, !to, "R6 fresh held");
    @(negedge clk);
    if (to) chk(w_start, 0, "R8 dropped item not reissued");
    if (busy) chk(r_start, 0, "R9 busy request ignored");
    chk(r_rdata, exp_rdata, "R7 client data");
    last_to = to;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    ctl(1'b0, 1'b0, "R1 in reset");
    chk(r_tmo, 0, "R1 tmo"); chk(r_fresh, 0, "R1 fresh"); chk(r_rdata, 0, "R1 rdata");
    rst_n = 1'b1;
    @(negedge clk);
    ctl(1'b0, 1'b0, "R1 after reset");
    chk(w_fresh, 0, "R1 fresh wr");

    access(8'h11, 8'hA1, 1, 0, 1'b0);
    access(8'h22, 8'hA2, W, 0, 1'b0);       // R10 boundary
    access(8'h33, 8'hA3, W + 1, 0, 1'b0);   // first edge past bound
    access(8'h44, 8'hA4, W, 1, 1'b0);       // R11 after timeout
    access(8'h55, 8'hA5, W + 4, 2, 1'b1);   // late done held, stray requests
    access(8'h66, 8'hA6, 3, 2, 1'b1);
    access(8'h77, 8'hA7, W + 2, 0, 1'b0);
    access(8'h88, 8'hA8, 2, 0, 1'b0);       // R8 new item after drop

    for (int k = 0; k < 40; k++) begin
      access(DW'($urandom), DW'($urandom), int'($urandom_range(W + 4, 1)),
             int'($urandom_range(2, 0)), logic'($urandom_range(1, 0)));
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule